// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to a usable state before the normal memory controller takes over. After reset it keeps clock enable and the data mask high and shows only no-operation commands on the command pins. It holds that quiet interval for a stabilization time given in clock cycles. It then closes every bank with one precharge-all command, waits out the precharge recovery time, and issues a series of auto-refresh commands with a fixed spacing between them.

The sequence ends with a mode register load. The address-bus value for that load is built from four configuration inputs: burst length code, burst type, CAS latency code and write mode. Every bit that the layout does not use is forced to zero. If the requested configuration uses a reserved code, the sequencer does not load the mode register. Instead it raises an error flag and stalls. After a legal load it shows only no-operation commands for the mode-settle time and then raises its done flag. Every timing interval is a parameter counted in clock cycles.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and at every point before init_done is set, cke and dqm are 1. During reset the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 4'b0111, addr and ba are 0, and init_done and cfg_err are 0.
- R2: After reset is released, the first WAIT_CYC-1 rising edges leave NOP on the pins. The precharge-all command appears on edge WAIT_CYC.
- R3: Precharge-all is encoded as 4'b0010. It drives addr bit 10 high, every other addr bit low, and ba = 0.
- R4: The first auto-refresh (encoding 4'b0001, addr = 0) appears exactly T_RP edges after precharge-all. NOP is on the pins in between.
- R5: REF_CNT auto-refreshes are issued, and a REF_CNT below 8 is raised to 8. Consecutive refreshes are T_RC edges apart, with NOP in between.
- R6: The mode register load (encoding 4'b0000) appears T_RC edges after the last refresh. Its addr carries burst length in bits 2..0, burst type in bit 3, CAS latency code in bits 6..4, and write mode in bit 9, where 0 means burst write and 1 means single-location write.
- R7: During the mode register load, addr bits 7, 8, 10 and 11 (and any higher bits) and ba are all 0.
- R8: After the load, NOP is shown for T_RSC-1 edges. init_done rises on edge T_RSC after the load and then stays high, with NOP on the pins, until reset.
- R9: CAS latency codes other than 3'b010 and 3'b011 are reserved. So are burst length codes 3'b100, 3'b101 and 3'b110, and code 3'b111 when burst type is 1. With any reserved code, no mode register load is issued. cfg_err rises on the edge where the load would have appeared and stays high, with NOP on the pins and init_done low, until reset.
- R10: Burst length code 3'b111 with burst type 0 (full page) is legal and is loaded like any other legal code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bl | input | 3 | Burst length code |
| cfg_bt | input | 1 | Burst type (0 sequential, 1 interleaved) |
| cfg_cl | input | 3 | CAS latency code |
| cfg_wm | input | 1 | Write mode (0 burst, 1 single location) |
| cke | output | 1 | Clock enable to memory |
| dqm | output | 1 | Data mask to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/column address bus |
| init_done | output | 1 | Initialization complete |
| cfg_err | output | 1 | Reserved configuration requested; stalled |

## Verification
Two events share one clock edge: the expiry of the last refresh interval and the legality decision on the configuration. On that edge the sequencer issues either the mode register load or the error stall. The bench runs the full sequence with legal codes, including full page, and with each class of reserved latency and burst-length code. On every clock it compares the command pins, address, bank and both flags against a behavioural expected stream. The shared edge is judged by whether a load word or a raised cfg_err appears there, and by nothing else.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_TRP,
    ST_TRC,
    ST_TRSC,
    ST_DONE,
    ST_STALL
  } boot_st_t;
endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= CW'(RST_VAL);
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_boot_mode.sv
module sdram_boot_mode #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        bl,
  input  logic              bt,
  input  logic [2:0]        cl,
  input  logic              wm,
  output logic [ADDR_W-1:0] word,
  output logic              ok
);
  logic bl_ok, cl_ok;

  always_comb begin
    word      = '0;
    word[2:0] = bl;
    word[3]   = bt;
    word[6:4] = cl;
    word[9]   = wm;
  end

  assign bl_ok = (bl[2] == 1'b0) || (bl == 3'b111 && !bt);
  assign cl_ok = (cl == 3'b010) || (cl == 3'b011);
  assign ok    = bl_ok && cl_ok;
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int WAIT_CYC = 20000,
  parameter int T_RP     = 3,
  parameter int T_RC     = 8,
  parameter int T_RSC    = 2,
  parameter int REF_CNT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_bl,
  input  logic              cfg_bt,
  input  logic [2:0]        cfg_cl,
  input  logic              cfg_wm,
  output logic              cke,
  output logic              dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              cfg_err
);
  localparam int REF_N = (REF_CNT < 8) ? 8 : REF_CNT;
  localparam int M1    = (WAIT_CYC > T_RP) ? WAIT_CYC : T_RP;
  localparam int M2    = (T_RC > T_RSC) ? T_RC : T_RSC;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int RW    = $clog2(REF_N + 1);

  boot_st_t          st_q, st_d;
  logic [RW-1:0]     refs_q, refs_d;
  logic              ld, tmr_zero;
  logic [CW-1:0]     ld_val;
  logic [3:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d, err_q, err_d;
  logic              cke_q, dqm_q;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_ok;

  sdram_boot_timer #(.CW(CW), .RST_VAL(WAIT_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(tmr_zero)
  );

  sdram_boot_mode #(.ADDR_W(ADDR_W)) u_mode (
    .bl(cfg_bl), .bt(cfg_bt), .cl(cfg_cl), .wm(cfg_wm),
    .word(mode_word), .ok(mode_ok)
  );

  always_comb begin
    st_d   = st_q;
    refs_d = refs_q;
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ld     = 1'b0;
    ld_val = '0;
    done_d = done_q;
    err_d  = err_q;
    case (st_q)
      ST_HOLD: if (tmr_zero) begin
        cmd_d      = CMD_PRE;
        addr_d[10] = 1'b1;
        ld         = 1'b1;
        ld_val     = CW'(T_RP - 1);
        st_d       = ST_TRP;
      end
      ST_TRP: if (tmr_zero) begin
        cmd_d  = CMD_REF;
        refs_d = RW'(1);
        ld     = 1'b1;
        ld_val = CW'(T_RC - 1);
        st_d   = ST_TRC;
      end
      ST_TRC: if (tmr_zero) begin
        if (refs_q == RW'(REF_N)) begin
          if (mode_ok) begin
            cmd_d  = CMD_MRS;
            addr_d = mode_word;
            ld     = 1'b1;
            ld_val = CW'(T_RSC - 1);
            st_d   = ST_TRSC;
          end else begin
            err_d = 1'b1;
            st_d  = ST_STALL;
          end
        end else begin
          cmd_d  = CMD_REF;
          refs_d = refs_q + 1'b1;
          ld     = 1'b1;
          ld_val = CW'(T_RC - 1);
        end
      end
      ST_TRSC: if (tmr_zero) begin
        done_d = 1'b1;
        st_d   = ST_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HOLD;
      refs_q <= '0;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      refs_q <= refs_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      done_q <= done_d;
      err_q  <= err_d;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr      = addr_q;
  assign ba        = '0;
  assign cke       = cke_q;
  assign dqm       = dqm_q;
  assign init_done = done_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int REF_CNT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              dqm,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              cfg_err
);
  localparam int REF_N = (REF_CNT < 8) ? 8 : REF_CNT;
  logic [3:0] cmd;
  int         ref_seen;
  logic       pre_seen;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_seen <= 0;
      pre_seen <= 1'b0;
    end else begin
      if (cmd == 4'b0001 && ref_seen < 1000) ref_seen <= ref_seen + 1;
      if (cmd == 4'b0010) pre_seen <= 1'b1;
    end
  end

  a_r1_cke_dqm_high: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (cke && dqm));
  a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> (addr == ADDR_W'(1 << 10) && ba == '0));
  a_r4_ref_after_pre: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0001) |-> pre_seen);
  a_r5_refs_before_load: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (ref_seen >= REF_N));
  a_r7_load_zero_fields: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (addr[ADDR_W-1:10] == '0 && addr[8:7] == 2'b00 && ba == '0));
  a_r9_load_legal_latency: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (addr[6:4] == 3'b010 || addr[6:4] == 3'b011));
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == 4'b0111));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r9_err_stall: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!init_done && cmd == 4'b0111));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

bind sdram_boot_seq sdram_boot_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W), .REF_CNT(REF_CNT)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done),
  .cfg_err(cfg_err)
);

// File: tb/sdram_boot_seq_bench.sv
module sdram_boot_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_C = 40;
  localparam int TRP_C  = 3;
  localparam int TRC_C  = 5;
  localparam int TRSC_C = 2;
  localparam int REFS   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_bl = 3'b000, cfg_cl = 3'b010;
  logic cfg_bt = 1'b0, cfg_wm = 1'b0;
  logic cke, dqm, cs_n, ras_n, cas_n, we_n, init_done, cfg_err;
  logic [1:0]  ba;
  logic [11:0] addr;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_boot_seq #(
    .ADDR_W(12), .BA_W(2), .WAIT_CYC(WAIT_C), .T_RP(TRP_C), .T_RC(TRC_C),
    .T_RSC(TRSC_C), .REF_CNT(REFS)
  ) u_sdram_boot_seq (
    .clk(clk), .rst(rst), .cfg_bl(cfg_bl), .cfg_bt(cfg_bt), .cfg_cl(cfg_cl),
    .cfg_wm(cfg_wm), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done),
    .cfg_err(cfg_err)
  );

  // expected observation: {cke,dqm,done,err,cmd[3:0],ba[1:0],addr[11:0]}
  function automatic logic [21:0] pack(input int cmd, input int a, input bit d, input bit e);
    return {1'b1, 1'b1, d, e, 4'(cmd), 2'b00, 12'(a)};
  endfunction

  function automatic logic [21:0] observed();
    return {cke, dqm, init_done, cfg_err, cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  task automatic check(input string tag, input logic [21:0] exp);
    logic [21:0] act = observed();
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [2:0] b, input logic t, input logic [2:0] c,
                          input logic w, input string load_tag);
    int q_cmd[$];
    int q_adr[$];
    string q_tag[$];
    bit legal = (c == 3'd2 || c == 3'd3) && (b < 3'd4 || (b == 3'd7 && !t));
    int word = int'(b) + int'(t) * 8 + int'(c) * 16 + int'(w) * 512;
    cfg_bl = b; cfg_bt = t; cfg_cl = c; cfg_wm = w;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", pack(7, 0, 1'b0, 1'b0));
    for (int i = 1; i < WAIT_C; i++) begin q_cmd.push_back(7); q_adr.push_back(0); q_tag.push_back("R2 hold NOP"); end
    q_cmd.push_back(2); q_adr.push_back(1024); q_tag.push_back("R3 precharge-all");
    for (int i = 1; i < TRP_C; i++) begin q_cmd.push_back(7); q_adr.push_back(0); q_tag.push_back("R4 tRP NOP"); end
    for (int r = 0; r < REFS; r++) begin
      q_cmd.push_back(1); q_adr.push_back(0); q_tag.push_back(r == 0 ? "R4 first refresh" : "R5 refresh");
      for (int i = 1; i < TRC_C; i++) begin q_cmd.push_back(7); q_adr.push_back(0); q_tag.push_back("R5 tRC NOP"); end
    end
    if (legal) begin
      q_cmd.push_back(0); q_adr.push_back(word); q_tag.push_back(load_tag);
      for (int i = 1; i < TRSC_C; i++) begin q_cmd.push_back(7); q_adr.push_back(0); q_tag.push_back("R8 tRSC NOP"); end
    end
    rst = 1'b0;
    while (q_cmd.size() > 0) begin
      @(negedge clk);
      check(q_tag.pop_front(), pack(q_cmd.pop_front(), q_adr.pop_front(), 1'b0, 1'b0));
    end
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (legal) check("R8 done held", pack(7, 0, 1'b1, 1'b0));
      else       check("R9 reserved stall", pack(7, 0, 1'b0, 1'b1));
    end
  endtask

  initial begin
    run_case(3'b011, 1'b0, 3'b010, 1'b0, "R6 load word BL8 CL2");
    run_case(3'b111, 1'b0, 3'b011, 1'b1, "R10 full page load");
    run_case(3'b000, 1'b1, 3'b011, 1'b0, "R6 load interleaved");
    run_case(3'b010, 1'b1, 3'b010, 1'b1, "R7 load single write");
    run_case(3'b001, 1'b0, 3'b100, 1'b0, "R9 unused");
    run_case(3'b111, 1'b1, 3'b010, 1'b0, "R9 unused");
    run_case(3'b101, 1'b0, 3'b011, 1'b0, "R9 unused");
    run_case(3'b010, 1'b0, 3'b000, 1'b1, "R9 unused");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule